// File: doc/BRIEF.md
# Scanline-Timed Repeating Interrupt Scheduler

This block raises a burst of interrupts lined up with video scanlines, the pattern a light-pen or light-gun position report needs. A host arms it with three values: a repeat count, a target line and a horizontal cycle offset. The block keeps its own free-running cycle counter and records the counter value at every frame-start marker it sees. On an arm it computes the first event time from the most recent recorded frame start: one full frame period later, plus the line's share of the frame, plus the horizontal offset. Each later event falls exactly one line period after the previous scheduled time, until the count is used up.

The frame period is the clock rate divided by the refresh rate. The line period is the frame period divided by the lines per frame. Both depend on a video-standard select that is sampled when the block is armed. Each event sets status bit 10 of a status word that other interrupt sources share. The host clears bits by writing zeros to them. Video timing generation and CPU interrupt masking belong to other blocks.

Top module: `scanline_irq_sched`

## Requirements
- R1: After reset, `irq_status` is zero and `busy` and `irq_pulse` are low.
- R2: With `std_sel`=0 (60 Hz: frame = CLK_HZ/60 cycles, 263 lines), the first event is seen on `irq_pulse` the cycle after clock edge F + frame + (line*frame)/263 + xoff, where F is the edge that sampled `frame_start`.
- R3: With `std_sel`=1 (50 Hz: frame = CLK_HZ/50 cycles, 314 lines), the same rule holds with 314 lines.
- R4: Each later event comes exactly frame/lines cycles (integer division) after the previous scheduled event.
- R5: An arm with a count N >= 1 gives exactly N events, and `busy` falls after the last one.
- R6: An arm with a count of zero or below (two's complement) gives exactly one event.
- R7: An event sets bit 10 (mask 0x400) of `irq_status` and leaves every other bit as it was.
- R8: A cycle with `stat_wr` high clears every status bit whose `stat_wdata` bit is 0 and keeps every bit whose data bit is 1.
- R9: When an event and a status write that clears bit 10 fall in the same cycle, bit 10 ends up set.
- R10: An arm while `busy` is high discards the pending schedule. Only the events of the new arm follow, and an old event due in the arm cycle itself is dropped.
- R11: The first event is timed from the latest frame start sampled before the arm. A scheduled event never lies before that frame start.
- R12: A bit raised on `irq_set` for one cycle is set in `irq_status` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle marker at the start of each video frame |
| std_sel | input | 1 | Video standard: 0 = 60 Hz / 263 lines, 1 = 50 Hz / 314 lines |
| arm | input | 1 | One-cycle request that starts a new burst |
| arm_count | input | CNT_W | Signed repeat count; zero or below means one event |
| arm_line | input | Y_W | Target line within the frame |
| arm_xoff | input | X_W | Horizontal offset in cycles |
| irq_set | input | STAT_W | Set requests from other interrupt sources |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | STAT_W | Write data; 0 bits clear, 1 bits keep |
| irq_status | output | STAT_W | Interrupt status word |
| irq_pulse | output | 1 | One-cycle pulse per event |
| busy | output | 1 | A burst is pending |

## Verification
An event that sets bit 10 and a host write that clears it can land on the same clock edge. The bench computes that edge from the frame start and the armed offset, then schedules a write of all zeros to be sampled there. The result passes only if bit 10 reads as set while an unrelated bit raised earlier reads as cleared. A follow-up write that clears bit 10 alone must then bring the word to zero.

// File: rtl/scanirq_pkg.sv
// Package: shared constants and helpers for the scanline interrupt scheduler.
// Assumes two video standards, indexed 0 (60 Hz) and 1 (50 Hz).
package scanirq_pkg;

    typedef enum logic {
        STD_60HZ = 1'b0,
        STD_50HZ = 1'b1
    } video_std_e;

    localparam int NUM_STD   = 2;
    localparam int EVENT_BIT = 10;

    // Refresh rate in Hz for a standard index.
    function automatic int refresh_hz(input int std_idx);
        return (std_idx == 0) ? 60 : 50;
    endfunction

    // Scanlines per frame for a standard index.
    function automatic int lines_per_frame(input int std_idx);
        return (std_idx == 0) ? 263 : 314;
    endfunction

endpackage

// File: rtl/scanirq_timebase.sv
// Timebase: free-running cycle counter plus a stamp of the counter value at
// the last sampled frame start. Assumes the counter wraps silently; all
// later arithmetic is modulo 2**TIME_W.
module scanirq_timebase #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    output logic [TIME_W-1:0] now_cnt,
    output logic [TIME_W-1:0] fs_stamp
);

    // Advance the cycle counter every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) now_cnt <= '0;
        else        now_cnt <= now_cnt + TIME_W'(1);
    end

    // Capture the counter value when a frame start is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n)           fs_stamp <= '0;
        else if (frame_start) fs_stamp <= now_cnt;
    end

endmodule

// File: rtl/scanirq_offset_calc.sv
// Offset calculator: for each video standard derives the frame period, the
// line period and the line offset, then picks one with std_sel and forms the
// absolute time of the first event. Purely combinational; assumes
// CLK_HZ/refresh fits TIME_W and arm_line*frame does not overflow TIME_W.
module scanirq_offset_calc
    import scanirq_pkg::*;
#(
    parameter int CLK_HZ = 252000,
    parameter int TIME_W = 32,
    parameter int Y_W    = 9,
    parameter int X_W    = 12
) (
    input  logic              std_sel,
    input  logic [Y_W-1:0]    arm_line,
    input  logic [X_W-1:0]    arm_xoff,
    input  logic [TIME_W-1:0] fs_stamp,
    output logic [TIME_W-1:0] first_target,
    output logic [TIME_W-1:0] line_period
);

    logic [TIME_W-1:0] frame_c [NUM_STD];
    logic [TIME_W-1:0] line_c  [NUM_STD];
    logic [TIME_W-1:0] yoff_c  [NUM_STD];

    // One set of timing constants and one line offset per standard.
    for (genvar s = 0; s < NUM_STD; s++) begin : g_std
        localparam int FRAME_CYC = CLK_HZ / refresh_hz(s);
        localparam int LINES     = lines_per_frame(s);
        localparam int LINE_CYC  = FRAME_CYC / LINES;

        assign frame_c[s] = TIME_W'(FRAME_CYC);
        assign line_c[s]  = TIME_W'(LINE_CYC);
        assign yoff_c[s]  = (TIME_W'(arm_line) * TIME_W'(FRAME_CYC)) / TIME_W'(LINES);
    end

    // Select the standard and add up the first event time.
    always_comb begin
        first_target = fs_stamp + frame_c[std_sel] + yoff_c[std_sel] + TIME_W'(arm_xoff);
        line_period  = line_c[std_sel];
    end

endmodule

// File: rtl/scanirq_sequencer.sv
// Sequencer: holds the pending schedule (next target time, remaining count,
// line period latched at arm) and fires when the counter reaches the target.
// Arm beats fire in the same cycle, so a re-arm drops the old schedule.
// Assumes the first target lies ahead of the counter at arm time.
module scanirq_sequencer #(
    parameter int TIME_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    arm,
    input  logic signed [CNT_W-1:0] arm_count,
    input  logic [TIME_W-1:0]       first_target,
    input  logic [TIME_W-1:0]       line_period,
    input  logic [TIME_W-1:0]       now_cnt,
    output logic                    fire,
    output logic                    pending,
    output logic signed [CNT_W-1:0] remain,
    output logic [TIME_W-1:0]       target,
    output logic [TIME_W-1:0]       line_q,
    output logic                    irq_pulse
);

    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

    logic more_left;

    // An event is due when the counter meets the target and no arm overrides it.
    always_comb begin
        fire      = pending && (now_cnt == target) && !arm;
        more_left = (remain > ONE);
    end

    // Load a new schedule on arm; step or retire it on each event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            remain  <= '0;
            target  <= '0;
            line_q  <= '0;
        end else if (arm) begin
            pending <= 1'b1;
            remain  <= arm_count;
            target  <= first_target;
            line_q  <= line_period;
        end else if (fire) begin
            if (more_left) begin
                remain <= remain - ONE;
                target <= target + line_q;
            end else begin
                pending <= 1'b0;
                remain  <= '0;
            end
        end
    end

    // Register a one-cycle pulse per event.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= fire;
    end

endmodule

// File: rtl/scanirq_status_reg.sv
// Status register: set requests from all sources OR into the word; a host
// write clears bits whose data bit is 0. A set wins over a clear of the same
// bit in the same cycle. Assumes EVT_BIT < STAT_W.
module scanirq_status_reg #(
    parameter int STAT_W  = 32,
    parameter int EVT_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_set,
    input  logic [STAT_W-1:0] irq_set,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] status
);

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] keep_vec;

    // Merge the scheduler event into the set vector; form the keep mask.
    always_comb begin
        set_vec          = irq_set;
        set_vec[EVT_BIT] = irq_set[EVT_BIT] | evt_set;
        keep_vec         = stat_wr ? stat_wdata : '1;
    end

    // Update the status word: clear first, then apply sets.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & keep_vec) | set_vec;
    end

endmodule

// File: rtl/scanline_irq_sched.sv
// Top: scanline-timed repeating interrupt scheduler. Ties together the
// timebase, offset calculator, sequencer and status register. Assumes
// frame_start and arm are one-cycle pulses; a frame start sampled in the
// same cycle as an arm is not used for that arm.
module scanline_irq_sched
    import scanirq_pkg::*;
#(
    parameter int CLK_HZ = 252000,
    parameter int TIME_W = 32,
    parameter int Y_W    = 9,
    parameter int X_W    = 12,
    parameter int CNT_W  = 8,
    parameter int STAT_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic                    std_sel,
    input  logic                    arm,
    input  logic signed [CNT_W-1:0] arm_count,
    input  logic [Y_W-1:0]          arm_line,
    input  logic [X_W-1:0]          arm_xoff,
    input  logic [STAT_W-1:0]       irq_set,
    input  logic                    stat_wr,
    input  logic [STAT_W-1:0]       stat_wdata,
    output logic [STAT_W-1:0]       irq_status,
    output logic                    irq_pulse,
    output logic                    busy
);

    logic [TIME_W-1:0]       now_cnt;
    logic [TIME_W-1:0]       fs_stamp;
    logic [TIME_W-1:0]       first_target;
    logic [TIME_W-1:0]       line_period;
    logic                    fire;
    logic                    pending;
    logic signed [CNT_W-1:0] remain;
    logic [TIME_W-1:0]       target;
    logic [TIME_W-1:0]       line_q;

    scanirq_timebase #(
        .TIME_W (TIME_W)
    ) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .now_cnt     (now_cnt),
        .fs_stamp    (fs_stamp)
    );

    scanirq_offset_calc #(
        .CLK_HZ (CLK_HZ),
        .TIME_W (TIME_W),
        .Y_W    (Y_W),
        .X_W    (X_W)
    ) u_offset (
        .std_sel      (std_sel),
        .arm_line     (arm_line),
        .arm_xoff     (arm_xoff),
        .fs_stamp     (fs_stamp),
        .first_target (first_target),
        .line_period  (line_period)
    );

    scanirq_sequencer #(
        .TIME_W (TIME_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm          (arm),
        .arm_count    (arm_count),
        .first_target (first_target),
        .line_period  (line_period),
        .now_cnt      (now_cnt),
        .fire         (fire),
        .pending      (pending),
        .remain       (remain),
        .target       (target),
        .line_q       (line_q),
        .irq_pulse    (irq_pulse)
    );

    scanirq_status_reg #(
        .STAT_W  (STAT_W),
        .EVT_BIT (EVENT_BIT)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_set    (fire),
        .irq_set    (irq_set),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .status     (irq_status)
    );

    // Expose the pending state.
    always_comb busy = pending;

endmodule

// File: rtl/scanirq_chk.sv
// Checker: temporal properties of the scheduler, bound into the top module.
// Assumes the top parameters are passed through unchanged.
module scanirq_chk #(
    parameter int TIME_W  = 32,
    parameter int CNT_W   = 8,
    parameter int STAT_W  = 32,
    parameter int EVT_BIT = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    arm,
    input logic                    fire,
    input logic                    busy,
    input logic                    irq_pulse,
    input logic                    stat_wr,
    input logic [STAT_W-1:0]       stat_wdata,
    input logic [STAT_W-1:0]       irq_status,
    input logic signed [CNT_W-1:0] remain,
    input logic [TIME_W-1:0]       target,
    input logic [TIME_W-1:0]       line_q,
    input logic [TIME_W-1:0]       fs_stamp
);

    localparam logic signed [CNT_W-1:0] ONE = CNT_W'(1);

    // R5: a pulse only follows a cycle in which a burst was pending.
    assert_pulse_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(busy));

    // R7: every pulse comes with bit 10 set in the status word.
    assert_event_sets_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_status[EVT_BIT]);

    // R8: a clearing write with no event leaves bit 10 low.
    assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && !stat_wdata[EVT_BIT] && !fire) |=> !irq_status[EVT_BIT]);

    // R9: event and clearing write in one cycle leave bit 10 set.
    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && stat_wr) |=> irq_status[EVT_BIT]);

    // R4: a continuing burst steps its target by exactly one line period.
    assert_line_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !arm && (remain > ONE)) |=> (target == $past(target) + $past(line_q)));

    // R6: the last event (count one or less) ends the burst.
    assert_last_event_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !arm && (remain <= ONE)) |=> !busy);

    // R11: a pending target never lies before the latest frame start.
    assert_target_after_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($signed(target - fs_stamp) >= 0));

endmodule

bind scanline_irq_sched scanirq_chk #(
    .TIME_W  (TIME_W),
    .CNT_W   (CNT_W),
    .STAT_W  (STAT_W),
    .EVT_BIT (scanirq_pkg::EVENT_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .fire       (fire),
    .busy       (busy),
    .irq_pulse  (irq_pulse),
    .stat_wr    (stat_wr),
    .stat_wdata (stat_wdata),
    .irq_status (irq_status),
    .remain     (remain),
    .target     (target),
    .line_q     (line_q),
    .fs_stamp   (fs_stamp)
);

// File: tb/test_scanline_irq_sched.sv
module test_scanline_irq_sched;

    localparam int CLK_HZ = 252000;
    localparam int STAT_W = 32;
    localparam int WDOG   = 150000;

    typedef struct packed {
        logic              std;
        logic [8:0]        y;
        logic [11:0]       x;
        logic signed [7:0] cnt;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 9'd0,   12'd0,  8'sd1},
        '{1'b0, 9'd100, 12'd7,  8'sd3},
        '{1'b1, 9'd262, 12'd30, 8'sd4},
        '{1'b1, 9'd10,  12'd0,  8'sd0},
        '{1'b0, 9'd5,   12'd2,  -8'sd3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              std_sel = 1'b0;
    logic              arm = 1'b0;
    logic signed [7:0] arm_count = '0;
    logic [8:0]        arm_line = '0;
    logic [11:0]       arm_xoff = '0;
    logic [STAT_W-1:0] irq_set = '0;
    logic              stat_wr = 1'b0;
    logic [STAT_W-1:0] stat_wdata = '0;
    logic [STAT_W-1:0] irq_status;
    logic              irq_pulse;
    logic              busy;

    int errors = 0;
    int checks = 0;
    int edge_n = 0;
    int ev_n = 0;
    int ev_t [256];

    always #2.5 clk = ~clk;

    scanline_irq_sched #(.CLK_HZ(CLK_HZ)) i_scanline_irq_sched (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .std_sel(std_sel),
        .arm(arm), .arm_count(arm_count), .arm_line(arm_line), .arm_xoff(arm_xoff),
        .irq_set(irq_set), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .irq_status(irq_status), .irq_pulse(irq_pulse), .busy(busy)
    );

    always @(posedge clk) edge_n <= edge_n + 1;

    // Log the edge number of each event pulse.
    always @(negedge clk) begin
        if (irq_pulse && ev_n < 256) begin
            ev_t[ev_n] = edge_n;
            ev_n = ev_n + 1;
        end
    end

    function automatic int frame_of(input logic s);
        return CLK_HZ / (s ? 50 : 60);
    endfunction
    function automatic int lines_of(input logic s);
        return s ? 314 : 263;
    endfunction
    function automatic int delay_of(input logic s, input int y, input int x);
        return frame_of(s) + (y * frame_of(s)) / lines_of(s) + x;
    endfunction
    function automatic int period_of(input logic s);
        return frame_of(s) / lines_of(s);
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_frame(output int f);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        f = edge_n;
    endtask

    task automatic do_arm(input logic s, input int y, input int x, input int c, output int base);
        @(negedge clk);
        std_sel = s; arm_line = 9'(y); arm_xoff = 12'(x); arm_count = 8'(c); arm = 1'b1;
        @(negedge clk) arm = 1'b0;
        base = ev_n;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic write_status(input logic [STAT_W-1:0] d);
        @(negedge clk) begin stat_wr = 1'b1; stat_wdata = d; end
        @(negedge clk) stat_wr = 1'b0;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int f, f2, base, n_exp, d, e;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "status after reset", irq_status, 0);
        check("R1", "busy after reset", busy, 0);
        check("R1", "pulse after reset", irq_pulse, 0);

        // R12: other sources set their bits
        @(negedge clk) irq_set = 32'h9;
        @(negedge clk) irq_set = '0;
        check("R12", "status after irq_set", irq_status, 32'h9);

        // Table walk: R2, R3, R4, R5, R6, R7
        for (int vi = 0; vi < NVEC; vi++) begin
            pulse_frame(f);
            repeat (3) @(negedge clk);
            do_arm(VECS[vi].std, int'(VECS[vi].y), int'(VECS[vi].x), int'(VECS[vi].cnt), base);
            wait_idle();
            n_exp = (VECS[vi].cnt > 0) ? int'(VECS[vi].cnt) : 1;
            d = delay_of(VECS[vi].std, int'(VECS[vi].y), int'(VECS[vi].x));
            check(VECS[vi].cnt > 0 ? "R5" : "R6", "event count", ev_n - base, n_exp);
            check(VECS[vi].std ? "R3" : "R2", "first event edge", ev_t[base], f + d);
            for (int k = 1; k < n_exp; k++)
                check("R4", "event spacing", ev_t[base + k] - ev_t[base + k - 1], period_of(VECS[vi].std));
            check("R7", "status after burst", irq_status, (vi == 0) ? 32'h409 : 32'h400);
            write_status('0);
        end

        // R11: a later frame start before the arm sets the time base
        pulse_frame(f);
        repeat (500) @(negedge clk);
        pulse_frame(f2);
        do_arm(1'b0, 3, 1, 1, base);
        wait_idle();
        check("R11", "first event from latest frame", ev_t[base], f2 + delay_of(1'b0, 3, 1));
        write_status('0);

        // R10: re-arm during a burst drops the old schedule
        pulse_frame(f);
        do_arm(1'b0, 0, 40, 8, base);
        while (edge_n != f + frame_of(1'b0) - 1) @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        f2 = edge_n;
        while (edge_n != f + frame_of(1'b0) + 45) @(negedge clk);
        check("R10", "old events before re-arm", ev_n - base, 1);
        do_arm(1'b0, 2, 5, 2, base);
        wait_idle();
        check("R10", "events after re-arm", ev_n - base, 2);
        check("R10", "first event of new arm", ev_t[base], f2 + delay_of(1'b0, 2, 5));
        check("R10", "second event of new arm", ev_t[base + 1], f2 + delay_of(1'b0, 2, 5) + period_of(1'b0));
        write_status('0);

        // R9 / R8: event and clearing write meet on one edge
        @(negedge clk) irq_set = 32'h8;
        @(negedge clk) irq_set = '0;
        pulse_frame(f);
        do_arm(1'b0, 0, 20, 1, base);
        e = f + delay_of(1'b0, 0, 20);
        while (edge_n != e - 1) @(negedge clk);
        stat_wr = 1'b1; stat_wdata = '0;
        @(negedge clk) stat_wr = 1'b0;
        check("R9", "bit 10 kept on collision", irq_status[10], 1);
        check("R8", "bit 3 cleared by write", irq_status, 32'h400);
        write_status(32'hFFFF_FBFF);
        check("R8", "bit 10 cleared, others kept", irq_status, 0);
        check("R5", "busy low at end", busy, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule